// File: doc/BRIEF.md
# Line-21 Caption Waveform Encoder

This block builds the digital luma waveform that carries two caption characters on one chosen video line. When the line counter hits the programmed caption line, in a field that the enable mode allows, the block takes over the luma path for that line. It waits a fixed number of samples after the line-start pulse and then sends a 26-bit serial frame at roughly 503 kHz. The frame holds a seven-cycle clock run-in, a three-bit start code and two bytes. Each byte carries seven character bits with a parity bit computed in hardware.

Software writes a byte pair for each field into registers outside this block. A write strobe tells the encoder that a new pair has arrived. For each field, a status flag drops to 0 on a write and rises to 1 once that pair has gone out on a caption line. If no new pair has arrived since the last encode, the line carries the null pair, two zero characters with correct parity. The bit clock is a fractional phase accumulator running on the 27 MHz sample clock, so bit edges do not drift across the frame.

Top module: `cap_line_encoder`

## Requirements
- R1: The frame has 26 bits, numbered 0 to 25. Bits 0..6 are run-in: each bit is high in its first half, where the phase fraction is below one half, and low in its second half. Bits 7, 8 and 9 carry the start code 0, 0, 1.
- R2: Bits 10..17 carry the first byte and bits 18..25 carry the second byte. Each byte goes out as its character bits [6:0], LSB first, followed by an odd-parity bit. The parity bit makes the eight bits hold an odd count of ones. The written bit 7 is ignored.
- R3: Let m count sample clocks from the start of the frame. Sample m belongs to bit floor(m·PHASE_INC / 2^PHASE_W), and its phase fraction is (m·PHASE_INC) mod 2^PHASE_W. The defaults (1221, 16) give about 53.7 clocks per bit. The frame ends after bit 25.
- R4: A matching lineStart sets capActive on the next clock. Sample m = 0 of the frame falls START_OFS clocks after that edge (default 283). Before that point capLevel stays at blank. After bit 25, capActive returns to 0. A lineStart that arrives while a line is active is ignored.
- R5: enMode selects the fields: 0 is off, 1 is odd fields only, 2 is even fields only, 3 is both. fieldOdd = 1 marks an odd field.
- R6: The caption line is lineReg + 4 when palMode = 0 and lineReg + 1 when palMode = 1. Any other line count causes no activity.
- R7: If a field's pair has not been written since its last encode, that field's line carries the null pair: both characters 0, with parity 1.
- R8: A write strobe clears that field's done flag and marks the pair as new. The done flag is set when a frame that carried a new pair for that field ends, as long as no further write arrived during that frame. A write during a frame keeps the flag at 0 and queues the new pair.
- R9: capLevel is only ever LEVEL_BLANK or LEVEL_HIGH. It is LEVEL_HIGH only for a 1 bit inside the frame, and it is LEVEL_BLANK whenever capActive is 0.
- R10: After reset, capActive is 0, capLevel is LEVEL_BLANK and both done flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| palMode | input | 1 | 0 selects the NTSC line offset, 1 selects PAL |
| enMode | input | 2 | Field enable mode |
| lineReg | input | 5 | Caption line register value |
| wrOdd | input | 1 | Pulse: a new odd-field pair has been written |
| oddByte0 | input | 8 | Odd-field first byte |
| oddByte1 | input | 8 | Odd-field second byte |
| wrEven | input | 1 | Pulse: a new even-field pair has been written |
| evenByte0 | input | 8 | Even-field first byte |
| evenByte1 | input | 8 | Even-field second byte |
| lineCount | input | LINE_W | Current line number |
| fieldOdd | input | 1 | 1 during odd fields |
| lineStart | input | 1 | One-clock pulse at the start of each line |
| capActive | output | 1 | Caption owns the luma on this line |
| capLevel | output | LEVEL_W | Luma code for the caption waveform |
| oddDone | output | 1 | Odd pair has been encoded |
| evenDone | output | 1 | Even pair has been encoded |

## Verification
The checks assume that lineStart is a single-clock pulse, that lineCount and fieldOdd hold steady for the whole line, and that the byte inputs change only together with their write strobe. They also assume that a write strobe never lands on the same clock as a matching lineStart. The stimulus meets these by driving every line through one task. That task holds the line number and field for about 1800 clocks and issues writes only well away from line starts. A mid-line lineStart and a mid-frame write are injected on purpose, at fixed offsets inside the frame.

// File: rtl/cap_enc_pkg.sv
package cap_enc_pkg;
  localparam int FRAME_BITS = 26;
  localparam int RUNIN_BITS = 7;
  localparam int DATA_FIRST = 10;

  typedef struct packed {
    logic       arm;
    logic       done;
    logic       active;
    logic       sending;
    logic       firstHalf;
    logic [4:0] bitIdx;
  } capStrobe_t;
endpackage

// File: rtl/cap_enc_ctrl.sv
module cap_enc_ctrl
  import cap_enc_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int PHASE_W   = 16,
  parameter int PHASE_INC = 1221,
  parameter int START_OFS = 283
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              palMode,
  input  logic [1:0]        enMode,
  input  logic [4:0]        lineReg,
  input  logic [LINE_W-1:0] lineCount,
  input  logic              fieldOdd,
  input  logic              lineStart,
  output capStrobe_t        stb
);
  localparam int CNT_W = $clog2(START_OFS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} capState_t;

  capState_t           state;
  logic [CNT_W-1:0]    waitCnt;
  logic [PHASE_W-1:0]  acc;
  logic [4:0]          bitIdx;
  logic [PHASE_W:0]    accSum;
  logic [LINE_W-1:0]   targetLine;
  logic                fieldOk, armReq, carry, lastBit;

  assign targetLine = LINE_W'(lineReg) + (palMode ? LINE_W'(1) : LINE_W'(4));
  assign fieldOk    = fieldOdd ? enMode[0] : enMode[1];
  assign armReq     = lineStart && fieldOk && (lineCount == targetLine);
  assign accSum     = {1'b0, acc} + (PHASE_W+1)'(PHASE_INC);
  assign carry      = accSum[PHASE_W];
  assign lastBit    = (bitIdx == 5'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      acc     <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        S_IDLE: if (armReq) begin
          state   <= S_WAIT;
          waitCnt <= '0;
        end
        S_WAIT: if (waitCnt == CNT_W'(START_OFS - 1)) begin
          state  <= S_SEND;
          acc    <= '0;
          bitIdx <= '0;
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
        S_SEND: begin
          acc <= accSum[PHASE_W-1:0];
          if (carry) begin
            if (lastBit) state <= S_IDLE;
            else         bitIdx <= bitIdx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.arm       = (state == S_IDLE) && armReq;
    stb.done      = (state == S_SEND) && carry && lastBit;
    stb.active    = (state != S_IDLE);
    stb.sending   = (state == S_SEND);
    stb.firstHalf = !acc[PHASE_W-1];
    stb.bitIdx    = bitIdx;
  end
endmodule

// File: rtl/cap_enc_dpath.sv
module cap_enc_dpath
  import cap_enc_pkg::*;
#(
  parameter int LEVEL_W     = 10,
  parameter int LEVEL_BLANK = 240,
  parameter int LEVEL_HIGH  = 520
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         stb,
  input  logic               fieldOdd,
  input  logic [1:0]         wrStb,
  input  logic [1:0][7:0]    firstByte,
  input  logic [1:0][7:0]    secondByte,
  output logic               capActive,
  output logic [LEVEL_W-1:0] capLevel,
  output logic [1:0]         doneFlag
);
  logic [1:0] fresh;
  logic       selOdd, usedFresh;
  logic [6:0] charA, charB;
  logic [15:0] dataBits;
  logic [3:0]  dataIdx;
  logic        frameBit;

  // Index 1 holds the odd field, index 0 the even field.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selOdd    <= 1'b0;
      usedFresh <= 1'b0;
      charA     <= '0;
      charB     <= '0;
    end else if (stb.arm) begin
      selOdd    <= fieldOdd;
      usedFresh <= fresh[fieldOdd];
      charA     <= fresh[fieldOdd] ? firstByte[fieldOdd][6:0]  : 7'd0;
      charB     <= fresh[fieldOdd] ? secondByte[fieldOdd][6:0] : 7'd0;
    end
  end

  for (genvar f = 0; f < 2; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fresh[f]    <= 1'b0;
        doneFlag[f] <= 1'b0;
      end else if (wrStb[f]) begin
        fresh[f]    <= 1'b1;
        doneFlag[f] <= 1'b0;
      end else begin
        if (stb.arm && (fieldOdd == (f == 1))) fresh[f] <= 1'b0;
        if (stb.done && (selOdd == (f == 1)) && usedFresh && !fresh[f])
          doneFlag[f] <= 1'b1;
      end
    end
  end

  assign dataBits = {~(^charB), charB, ~(^charA), charA};
  assign dataIdx  = 4'(stb.bitIdx - 5'(DATA_FIRST));

  always_comb begin
    if (stb.bitIdx < 5'(RUNIN_BITS))       frameBit = stb.firstHalf;
    else if (stb.bitIdx < 5'(DATA_FIRST-1)) frameBit = 1'b0;
    else if (stb.bitIdx == 5'(DATA_FIRST-1)) frameBit = 1'b1;
    else                                    frameBit = dataBits[dataIdx];
  end

  assign capActive = stb.active;
  assign capLevel  = (stb.sending && frameBit) ? LEVEL_W'(LEVEL_HIGH) : LEVEL_W'(LEVEL_BLANK);
endmodule

// File: rtl/cap_line_encoder.sv
module cap_line_encoder
  import cap_enc_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int PHASE_W     = 16,
  parameter int PHASE_INC   = 1221,
  parameter int START_OFS   = 283,
  parameter int LEVEL_W     = 10,
  parameter int LEVEL_BLANK = 240,
  parameter int LEVEL_HIGH  = 520
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               palMode,
  input  logic [1:0]         enMode,
  input  logic [4:0]         lineReg,
  input  logic               wrOdd,
  input  logic [7:0]         oddByte0,
  input  logic [7:0]         oddByte1,
  input  logic               wrEven,
  input  logic [7:0]         evenByte0,
  input  logic [7:0]         evenByte1,
  input  logic [LINE_W-1:0]  lineCount,
  input  logic               fieldOdd,
  input  logic               lineStart,
  output logic               capActive,
  output logic [LEVEL_W-1:0] capLevel,
  output logic               oddDone,
  output logic               evenDone
);
  capStrobe_t stb;
  logic [1:0] doneFlag;

  cap_enc_ctrl #(
    .LINE_W(LINE_W), .PHASE_W(PHASE_W), .PHASE_INC(PHASE_INC), .START_OFS(START_OFS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .palMode(palMode), .enMode(enMode), .lineReg(lineReg),
    .lineCount(lineCount), .fieldOdd(fieldOdd), .lineStart(lineStart), .stb(stb)
  );

  cap_enc_dpath #(
    .LEVEL_W(LEVEL_W), .LEVEL_BLANK(LEVEL_BLANK), .LEVEL_HIGH(LEVEL_HIGH)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .fieldOdd(fieldOdd),
    .wrStb({wrOdd, wrEven}),
    .firstByte({oddByte0, evenByte0}),
    .secondByte({oddByte1, evenByte1}),
    .capActive(capActive), .capLevel(capLevel), .doneFlag(doneFlag)
  );

  assign oddDone  = doneFlag[1];
  assign evenDone = doneFlag[0];
endmodule

// File: rtl/cap_line_encoder_chk.sv
module cap_line_encoder_chk #(
  parameter int LEVEL_W     = 10,
  parameter int LEVEL_BLANK = 240,
  parameter int LEVEL_HIGH  = 520
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         enMode,
  input logic               lineStart,
  input logic               wrOdd,
  input logic               wrEven,
  input logic               capActive,
  input logic [LEVEL_W-1:0] capLevel,
  input logic               oddDone,
  input logic               evenDone
);
  p_blank_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !capActive |-> capLevel == LEVEL_W'(LEVEL_BLANK));

  p_two_levels_r9: assert property (@(posedge clk) disable iff (!rstN)
    capLevel == LEVEL_W'(LEVEL_BLANK) || capLevel == LEVEL_W'(LEVEL_HIGH));

  p_arm_after_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capActive) |-> $past(lineStart));

  p_off_mode_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capActive) |-> $past(enMode) != 2'd0);

  p_odd_write_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrOdd |=> !oddDone);

  p_even_write_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEven |=> !evenDone);

  p_odd_done_at_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oddDone) |-> $fell(capActive));

  p_even_done_at_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evenDone) |-> $fell(capActive));
endmodule

bind cap_line_encoder cap_line_encoder_chk #(
  .LEVEL_W(LEVEL_W), .LEVEL_BLANK(LEVEL_BLANK), .LEVEL_HIGH(LEVEL_HIGH)
) chk_i (
  .clk(clk), .rstN(rstN), .enMode(enMode), .lineStart(lineStart),
  .wrOdd(wrOdd), .wrEven(wrEven), .capActive(capActive), .capLevel(capLevel),
  .oddDone(oddDone), .evenDone(evenDone)
);

// File: tb/cap_line_encoder_tb_top.sv
module cap_line_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S_OFS  = 283;
  localparam int P_INC  = 1221;
  localparam int BLANK  = 240;
  localparam int HIGH   = 520;
  localparam int LINE_CLKS = 1800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic palMode = 1'b0;
  logic [1:0] enMode = 2'd0;
  logic [4:0] lineReg = 5'h11;
  logic wrOdd = 1'b0, wrEven = 1'b0;
  logic [7:0] oddByte0 = 8'h00, oddByte1 = 8'h00, evenByte0 = 8'h00, evenByte1 = 8'h00;
  logic [9:0] lineCount = '0;
  logic fieldOdd = 1'b0;
  logic lineStart = 1'b0;
  logic capActive;
  logic [9:0] capLevel;
  logic oddDone, evenDone;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_line_encoder dut_i (
    .clk(clk), .rstN(rstN), .palMode(palMode), .enMode(enMode), .lineReg(lineReg),
    .wrOdd(wrOdd), .oddByte0(oddByte0), .oddByte1(oddByte1),
    .wrEven(wrEven), .evenByte0(evenByte0), .evenByte1(evenByte1),
    .lineCount(lineCount), .fieldOdd(fieldOdd), .lineStart(lineStart),
    .capActive(capActive), .capLevel(capLevel), .oddDone(oddDone), .evenDone(evenDone)
  );

  // Behavioural reference: index 1 = odd field, 0 = even field.
  bit mActive = 0;
  int j = 0;
  bit mFieldOdd = 0;
  bit mUsedFresh = 0;
  bit mFresh [2] = '{0, 0};
  bit mDone [2] = '{0, 0};
  int mChar [2] = '{0, 0};

  function automatic bit oddPar(int c);
    int ones = 0;
    for (int k = 0; k < 7; k++) ones += (c >> k) & 1;
    return (ones % 2) == 0;
  endfunction

  function automatic bit expBit(int b, int frac);
    int c;
    if (b < 7) return frac < 32768;          // R1 run-in
    if (b == 7 || b == 8) return 1'b0;       // R1 start code
    if (b == 9) return 1'b1;
    c = (b < 18) ? mChar[0] : mChar[1];      // R2 byte order
    if (b == 17 || b == 25) return oddPar(c);
    return ((c >> ((b - 10) % 8)) & 1) == 1;
  endfunction

  always @(posedge clk) begin
    int tl;
    bit fieldOk;
    if (!rstN) begin
      mActive = 0; j = 0; mFresh = '{0, 0}; mDone = '{0, 0};
    end else begin
      if (mActive) begin
        j++;
        if (j >= S_OFS && (((j - S_OFS) * P_INC) >>> 16) >= 26) begin
          mActive = 0;
          if (mUsedFresh && !mFresh[mFieldOdd]) mDone[mFieldOdd] = 1;
        end
      end else begin
        tl = int'(lineReg) + (palMode ? 1 : 4);
        fieldOk = fieldOdd ? enMode[0] : enMode[1];
        if (lineStart && fieldOk && int'(lineCount) == tl) begin
          mActive = 1; j = 0; mFieldOdd = fieldOdd;
          mUsedFresh = mFresh[fieldOdd];
          mChar[0] = mUsedFresh ? int'(fieldOdd ? oddByte0[6:0] : evenByte0[6:0]) : 0;
          mChar[1] = mUsedFresh ? int'(fieldOdd ? oddByte1[6:0] : evenByte1[6:0]) : 0;
          mFresh[fieldOdd] = 0;
        end
      end
      if (wrOdd)  begin mFresh[1] = 1; mDone[1] = 0; end
      if (wrEven) begin mFresh[0] = 1; mDone[0] = 0; end
    end
  end

  always @(negedge clk) begin
    int eLevel, m, b, frac;
    string tag;
    if (!finished) begin
      tag = rstN ? "R4/R5/R6" : "R10";
      eLevel = BLANK;
      if (mActive && j >= S_OFS) begin
        m = j - S_OFS; b = (m * P_INC) >>> 16; frac = (m * P_INC) & 65535;
        eLevel = expBit(b, frac) ? HIGH : BLANK;
        tag = (b < 10) ? "R1/R3" : (mUsedFresh ? "R2/R3" : "R7/R3");
      end else if (mActive) tag = "R4";
      vectors++;
      if (capActive !== mActive) begin
        fails++;
        $display("FAIL %s capActive: actual %0b expected %0b at j=%0d", rstN ? "R4/R5/R6" : "R10", capActive, mActive, j);
      end
      if (capLevel !== 10'(eLevel)) begin
        fails++;
        $display("FAIL %s/R9 capLevel: actual %0d expected %0d at j=%0d", tag, capLevel, eLevel, j);
      end
      if (oddDone !== mDone[1] || evenDone !== mDone[0]) begin
        fails++;
        $display("FAIL %s done flags: actual %0b%0b expected %0b%0b", rstN ? "R8" : "R10",
                 oddDone, evenDone, mDone[1], mDone[0]);
      end
    end
  end

  task automatic writePair(input bit odd, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk);
    if (odd) begin oddByte0 = b0; oddByte1 = b1; wrOdd = 1; end
    else     begin evenByte0 = b0; evenByte1 = b1; wrEven = 1; end
    @(negedge clk);
    wrOdd = 0; wrEven = 0;
  endtask

  // opt 1: stray lineStart mid-line, opt 2: write during frame
  task automatic runLine(input int ln, input bit odd, input int opt);
    @(negedge clk);
    lineCount = 10'(ln); fieldOdd = odd; lineStart = 1;
    @(negedge clk);
    lineStart = 0;
    for (int c = 0; c < LINE_CLKS; c++) begin
      if (c == 500 && opt == 1) begin
        lineStart = 1; @(negedge clk); lineStart = 0;
      end else if (c == 800 && opt == 2) begin
        writePair(odd, 8'h35, 8'h36);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);            // R10 reset state compared each clock
    rstN = 1;
    repeat (3) @(negedge clk);
    runLine(21, 1, 0);                    // R5: mode 0, nothing happens
    enMode = 2'd1;
    writePair(1, 8'h41, 8'hC2);           // R2: bit 7 of second byte ignored
    runLine(21, 0, 0);                    // R5: even field with odd-only mode
    runLine(20, 1, 0);                    // R6: wrong line
    runLine(21, 1, 0);                    // R1/R2/R3/R8: odd frame, done rises
    runLine(21, 1, 1);                    // R7 null pair, R4 stray lineStart ignored
    enMode = 2'd2;
    runLine(21, 0, 0);                    // R5/R7: even null pair, flag stays 0
    writePair(0, 8'h7F, 8'h01);
    runLine(21, 0, 2);                    // R8: write during frame keeps flag low
    runLine(21, 0, 0);                    // R8: queued pair sent, flag rises
    palMode = 1; enMode = 2'd3;
    writePair(1, 8'h20, 8'h55);
    runLine(21, 1, 0);                    // R6: PAL offset, old line no longer matches
    runLine(18, 1, 0);                    // R6: PAL line = lineReg + 1
    lineReg = 5'h05;
    writePair(0, 8'h00, 8'hFF);
    runLine(6, 0, 0);                     // R6/R2: other register value
    repeat (5) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule